// File: doc/BRIEF.md
# I2C Register Bank for a Five-Channel Code Output Device

This block is the serial front end of a device that holds five 8-bit output codes and four open-collector general-purpose ports. A bus master writes the codes and the port controls over a standard I2C link. It reads back one status byte. The status byte reports a sticky power-up flag and the live levels of the four port pins.

The block oversamples SCL and SDA with a fast system clock. Each line passes through a synchronizer and a glitch filter. The block then detects START, repeated START and STOP, and it drives an SDA pull-low enable for acknowledges and read data. The slave address has a fixed upper nibble. Its low three bits come from strap inputs.

A write transfer carries a register pointer byte and then any number of data bytes. The pointer advances after every data byte. The register contents are presented as parallel outputs for the analog and pad logic that sits outside this block.

Top module: `i2c_dac_regbank`

## Requirements
- R1: The block answers only the 7-bit address binary 0100 followed by `addrSel[2]`, `addrSel[1]`, `addrSel[0]`, sent MSB first and followed by the R/W bit (0 = write, 1 = read). For any other address it gives no acknowledge and ignores every later byte until the next START.
- R2: In a write, the first byte after the address is the register pointer. Only its low three bits matter; bits 7 to 3 are ignored.
- R3: Pointer 000 selects the control register. Data bit 7 drives `ctrlRef`, and data bits 3 to 0 drive `portDrive[3:0]`. A 1 in a port bit means the pin's pull-down is switched on.
- R4: Pointers 001 to 101 select the code of channel 0 to 4, which appears on `dacCode[8*ch +: 8]`.
- R5: The pointer increments after each data byte, so one transfer can fill consecutive registers.
- R6: Data bytes written to pointers 110 and 111 are acknowledged and change no output.
- R7: In a matched transfer, every byte the block receives is acknowledged by `sdaPullLow` being high through the ninth SCL clock. Outside acknowledges and read data bits, `sdaPullLow` is low.
- R8: A read returns the status byte MSB first, changing on SCL low: bit 7 is the power-up flag, bits 6 to 4 are 0, and bits 3 to 0 are the levels of `portIn[3:0]`. Each master acknowledge brings the status byte again.
- R9: The power-up flag is 1 after reset. It becomes 0 at the STOP that ends a transfer in which a full status byte was sent, and it stays 0 until the next reset.
- R10: Reset clears the control register and all five codes to 0.
- R11: A master NACK after a read byte ends data output: SDA stays released until the next START.
- R12: A repeated START during any phase restarts address reception. The values written before it are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset (also the power-up event) |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level (wired bus value) |
| addrSel | input | 3 | Strap levels for the low three address bits |
| portIn | input | 4 | Levels sensed on the four port pins |
| sdaPullLow | output | 1 | 1 = pull SDA low, 0 = release |
| ctrlRef | output | 1 | Reference-select bit of the control register |
| portDrive | output | 4 | Pull-down enables for the four port pins |
| dacCode | output | 40 | Five 8-bit channel codes, channel 0 in bits 7:0 |

## Verification
The hardest state to reach from the ports is the clearing of the power-up flag. The flag falls only at a STOP that follows a completely shifted status byte, and once it falls, no write can bring it back. The bench reads the status byte twice and ends the first read with a NACK and a STOP, so the flag is seen as 1 and then as 0. It then pulses reset and reads again to see the flag return. Writes to the two unused pointers are reached by a long burst that starts at channel 0 and runs past channel 4. A repeated START is issued in the middle of a write to show that the pointer is reloaded.

// File: rtl/i2cdac_pkg.sv
package i2cdac_pkg;
  localparam int NUM_CH    = 5;
  localparam int CODE_W    = 8;
  localparam int PTR_W     = 3;
  localparam int NUM_PORTS = 4;
  localparam int SEL_W     = 3;
  localparam logic [3:0] DEV_ID = 4'b0100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } busState_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_SUB, PH_DATA
  } phase_t;

  typedef struct packed {
    logic              subLoad;
    logic              dataWrite;
    logic              ponClear;
    logic [CODE_W-1:0] rxByte;
  } strobe_t;
endpackage

// File: rtl/i2cdac_sync.sv
module i2cdac_sync #(
  parameter int WIDTH    = 2,
  parameter int FILT_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] lineIn,
  output logic [WIDTH-1:0] lineOut
);
  localparam int CNT_W = $clog2(FILT_LEN) + 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic             meta1, meta2, filtQ;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta1 <= 1'b1;
        meta2 <= 1'b1;
        filtQ <= 1'b1;
        cnt   <= '0;
      end else begin
        meta1 <= lineIn[i];
        meta2 <= meta1;
        if (meta2 == filtQ) begin
          cnt <= '0;
        end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
          filtQ <= meta2;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign lineOut[i] = filtQ;
  end
endmodule

// File: rtl/i2cdac_ctrl.sv
module i2cdac_ctrl
  import i2cdac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [SEL_W-1:0]  addrSel,
  input  logic [CODE_W-1:0] statusByte,
  output strobe_t           strb,
  output logic              sdaPullLow
);
  busState_t         state;
  phase_t            phase;
  logic              sclD, sdaD;
  logic [CODE_W-1:0] shiftReg, txReg;
  logic [2:0]        bitCnt;
  logic              byteDone, rwBit, readDone, mNack;

  logic sclRise, sclFall, startC, stopC, addrHit;
  assign sclRise = sclF & ~sclD;
  assign sclFall = ~sclF & sclD;
  assign startC  = sclF & sclD & sdaD & ~sdaF;
  assign stopC   = sclF & sclD & ~sdaD & sdaF;
  assign addrHit = (shiftReg[7:1] == {DEV_ID, addrSel});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      sclD     <= 1'b1;
      sdaD     <= 1'b1;
      shiftReg <= '0;
      txReg    <= '0;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      rwBit    <= 1'b0;
      readDone <= 1'b0;
      mNack    <= 1'b0;
      strb     <= '0;
    end else begin
      sclD           <= sclF;
      sdaD           <= sdaF;
      strb.subLoad   <= 1'b0;
      strb.dataWrite <= 1'b0;
      strb.ponClear  <= 1'b0;
      if (startC) begin
        state    <= ST_RX;
        phase    <= PH_ADDR;
        bitCnt   <= '0;
        byteDone <= 1'b0;
      end else if (stopC) begin
        state         <= ST_IDLE;
        strb.ponClear <= readDone;
        readDone      <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (sclRise) begin
              shiftReg <= {shiftReg[6:0], sdaF};
              bitCnt   <= bitCnt + 1'b1;
              if (bitCnt == 3'd7) byteDone <= 1'b1;
            end
            if (sclFall && byteDone) begin
              byteDone <= 1'b0;
              unique case (phase)
                PH_ADDR: begin
                  if (addrHit) begin
                    state <= ST_ACK;
                    rwBit <= shiftReg[0];
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                PH_SUB: begin
                  state        <= ST_ACK;
                  strb.subLoad <= 1'b1;
                  strb.rxByte  <= shiftReg;
                end
                default: begin
                  state          <= ST_ACK;
                  strb.dataWrite <= 1'b1;
                  strb.rxByte    <= shiftReg;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (phase == PH_ADDR && rwBit) begin
                state <= ST_TX;
                txReg <= statusByte;
              end else begin
                state <= ST_RX;
                phase <= (phase == PH_ADDR) ? PH_SUB : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              txReg  <= {txReg[6:0], 1'b0};
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == 3'd7) begin
                state    <= ST_MACK;
                readDone <= 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (sclRise) mNack <= sdaF;
            if (sclFall) begin
              if (mNack) begin
                state <= ST_IDLE;
              end else begin
                state  <= ST_TX;
                txReg  <= statusByte;
                bitCnt <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaPullLow = (state == ST_ACK) | ((state == ST_TX) & ~txReg[7]);
endmodule

// File: rtl/i2cdac_regs.sv
module i2cdac_regs
  import i2cdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [NUM_PORTS-1:0]     portIn,
  output logic                     ctrlRef,
  output logic [NUM_PORTS-1:0]     portDrive,
  output logic [NUM_CH*CODE_W-1:0] dacCode,
  output logic [CODE_W-1:0]        statusByte,
  output logic [PTR_W-1:0]         subPtr,
  output logic                     ponFlag
);
  logic [NUM_PORTS-1:0] portM1, portM2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subPtr    <= '0;
      ctrlRef   <= 1'b0;
      portDrive <= '0;
      ponFlag   <= 1'b1;
      portM1    <= '0;
      portM2    <= '0;
    end else begin
      portM1 <= portIn;
      portM2 <= portM1;
      if (strb.ponClear) ponFlag <= 1'b0;
      if (strb.subLoad) begin
        subPtr <= strb.rxByte[PTR_W-1:0];
      end else if (strb.dataWrite) begin
        subPtr <= subPtr + 1'b1;
        if (subPtr == '0) begin
          ctrlRef   <= strb.rxByte[CODE_W-1];
          portDrive <= strb.rxByte[NUM_PORTS-1:0];
        end
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0] codeQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        codeQ <= '0;
      else if (strb.dataWrite && subPtr == PTR_W'(ch + 1))
        codeQ <= strb.rxByte;
    end
    assign dacCode[ch*CODE_W +: CODE_W] = codeQ;
  end

  assign statusByte = {ponFlag, {(CODE_W-1-NUM_PORTS){1'b0}}, portM2};
endmodule

// File: rtl/i2c_dac_regbank.sv
module i2c_dac_regbank
  import i2cdac_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  input  logic [SEL_W-1:0]         addrSel,
  input  logic [NUM_PORTS-1:0]     portIn,
  output logic                     sdaPullLow,
  output logic                     ctrlRef,
  output logic [NUM_PORTS-1:0]     portDrive,
  output logic [NUM_CH*CODE_W-1:0] dacCode
);
  logic [1:0]        lineF;
  logic              sclF, sdaF, ponFlag;
  logic [CODE_W-1:0] statusByte;
  logic [PTR_W-1:0]  subPtr;
  strobe_t           strb;

  i2cdac_sync #(.WIDTH(2), .FILT_LEN(FILT_LEN)) u_sync (
    .clk(clk), .rstN(rstN), .lineIn({sclIn, sdaIn}), .lineOut(lineF)
  );
  assign sclF = lineF[1];
  assign sdaF = lineF[0];

  i2cdac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .addrSel(addrSel),
    .statusByte(statusByte), .strb(strb), .sdaPullLow(sdaPullLow)
  );

  i2cdac_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .portIn(portIn), .ctrlRef(ctrlRef),
    .portDrive(portDrive), .dacCode(dacCode), .statusByte(statusByte),
    .subPtr(subPtr), .ponFlag(ponFlag)
  );
endmodule

// File: rtl/i2cdac_checker.sv
module i2cdac_checker
  import i2cdac_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     sclF,
  input logic                     sdaPullLow,
  input strobe_t                  strb,
  input logic [PTR_W-1:0]         subPtr,
  input logic                     ponFlag,
  input logic                     ctrlRef,
  input logic [NUM_PORTS-1:0]     portDrive,
  input logic [NUM_CH*CODE_W-1:0] dacCode
);
  // R7: SDA drive only moves while the filtered clock is low
  a_r7_sda_moves_on_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclF);

  // R3: port controls change only from a data write at pointer 0
  a_r3_ctrl_from_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portDrive) |-> ($past(strb.dataWrite) && $past(subPtr) == '0));

  // R4: codes change only from a data write at pointers 1..NUM_CH
  a_r4_code_from_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacCode) |-> ($past(strb.dataWrite) && $past(subPtr) != '0
                           && $past(subPtr) <= PTR_W'(NUM_CH)));

  // R5: pointer advances by one per data byte
  a_r5_ptr_advance: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWrite |=> subPtr == $past(subPtr) + 1'b1);

  // R6: writes beyond the last channel leave outputs alone
  a_r6_unused_discard: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWrite && subPtr > PTR_W'(NUM_CH))
      |=> ($stable(dacCode) && $stable(portDrive) && $stable(ctrlRef)));

  // R9: flag falls only on a clear strobe and never comes back without reset
  a_r9_pon_clear_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ponFlag) |-> $past(strb.ponClear));
  a_r9_pon_stays_low: assert property (@(posedge clk) disable iff (!rstN)
    !ponFlag |=> !ponFlag);
endmodule

bind i2c_dac_regbank i2cdac_checker u_chk (
  .clk(clk), .rstN(rstN), .sclF(sclF), .sdaPullLow(sdaPullLow), .strb(strb),
  .subPtr(subPtr), .ponFlag(ponFlag), .ctrlRef(ctrlRef),
  .portDrive(portDrive), .dacCode(dacCode)
);

// File: tb/i2c_dac_regbank_bench.sv
module i2c_dac_regbank_bench;
  localparam int Q = 25;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scl = 1'b1;
  logic        sdaM = 1'b1;
  logic [2:0]  addrSel = 3'b101;
  logic [3:0]  portIn = 4'b1010;
  logic        sdaPullLow, ctrlRef;
  logic [3:0]  portDrive;
  logic [39:0] dacCode;
  logic        sdaBus;
  int          nChecks = 0;
  int          nFails = 0;

  always #10 clk = ~clk;
  assign sdaBus = sdaM & ~sdaPullLow;

  i2c_dac_regbank u_i2c_dac_regbank (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .addrSel(addrSel),
    .portIn(portIn), .sdaPullLow(sdaPullLow), .ctrlRef(ctrlRef),
    .portDrive(portDrive), .dacCode(dacCode)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); scl = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); scl = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaM = b; waitQ(); scl = 1'b1; waitQ();
    seen = sdaBus; waitQ(); scl = 1'b0; waitQ();
  endtask

  // writes a byte; SDA must follow the master bits (R7), returns acknowledge
  task automatic wrByte(input logic [7:0] b, output logic ack);
    logic seen;
    logic clean = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clockBit(b[i], seen);
      if (seen != b[i]) clean = 1'b0;
    end
    chk(clean, "R7 SDA released during data bits", {63'd0, clean}, 64'd1);
    clockBit(1'b1, seen);
    ack = ~seen;
  endtask

  task automatic rdByte(input logic ackIt, output logic [7:0] b);
    logic seen;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, seen);
      b[i] = seen;
    end
    clockBit(~ackIt, seen);
  endtask

  function automatic logic [7:0] code(input int ch);
    return dacCode[8*ch +: 8];
  endfunction

  task automatic t_reset();
    chk(dacCode == 40'd0, "R10 codes clear", {24'd0, dacCode}, 64'd0);
    chk(ctrlRef == 1'b0 && portDrive == 4'd0, "R10 control clear",
        {59'd0, ctrlRef, portDrive}, 64'd0);
    chk(sdaPullLow == 1'b0, "R7 idle release", {63'd0, sdaPullLow}, 64'd0);
  endtask

  task automatic t_mismatch();
    logic ack;
    busStart();
    wrByte(8'h4C, ack);
    chk(!ack, "R1 wrong strap bits not acked", {63'd0, ack}, 64'd0);
    wrByte(8'h01, ack);
    chk(!ack, "R1 later byte ignored", {63'd0, ack}, 64'd0);
    wrByte(8'h5A, ack);
    busStop();
    chk(dacCode == 40'd0, "R1 no write after mismatch", {24'd0, dacCode}, 64'd0);
    busStart();
    wrByte(8'h2A, ack);
    chk(!ack, "R1 wrong fixed nibble not acked", {63'd0, ack}, 64'd0);
    busStop();
  endtask

  task automatic t_write_ctrl();
    logic ack;
    busStart();
    wrByte(8'h4A, ack);
    chk(ack, "R1 matching address acked", {63'd0, ack}, 64'd1);
    wrByte(8'hF8, ack);
    chk(ack, "R7 pointer acked", {63'd0, ack}, 64'd1);
    wrByte(8'h8F, ack);
    chk(ack, "R7 data acked", {63'd0, ack}, 64'd1);
    chk(ctrlRef == 1'b1 && portDrive == 4'hF, "R2 R3 control via pointer F8",
        {59'd0, ctrlRef, portDrive}, 64'h1F);
    wrByte(8'h05, ack);
    busStop();
    chk(code(0) == 8'h05, "R5 pointer advanced to channel 0", {56'd0, code(0)}, 64'h05);
  endtask

  task automatic t_burst();
    logic ack;
    logic [39:0] snap;
    busStart();
    wrByte(8'h4A, ack);
    wrByte(8'h21, ack);
    for (int ch = 0; ch < 5; ch++) wrByte(8'h11 * (ch + 1), ack);
    chk(dacCode == 40'h55_44_33_22_11, "R4 R5 all channels", {24'd0, dacCode},
        64'h55_44_33_22_11);
    wrByte(8'h99, ack);
    chk(ack, "R6 pointer 6 acked", {63'd0, ack}, 64'd1);
    wrByte(8'h77, ack);
    chk(ack, "R6 pointer 7 acked", {63'd0, ack}, 64'd1);
    snap = dacCode;
    busStop();
    chk(snap == 40'h55_44_33_22_11 && portDrive == 4'hF && ctrlRef,
        "R6 unused pointers discarded", {24'd0, snap}, 64'h55_44_33_22_11);
  endtask

  task automatic t_restart();
    logic ack;
    busStart();
    wrByte(8'h4A, ack);
    wrByte(8'h02, ack);
    wrByte(8'h3C, ack);
    busStart();
    wrByte(8'h4A, ack);
    chk(ack, "R12 address after repeated START", {63'd0, ack}, 64'd1);
    wrByte(8'h0B, ack);
    wrByte(8'h4D, ack);
    busStop();
    chk(code(1) == 8'h3C, "R12 value before restart kept", {56'd0, code(1)}, 64'h3C);
    chk(code(2) == 8'h4D, "R12 pointer reloaded", {56'd0, code(2)}, 64'h4D);
  endtask

  task automatic t_read();
    logic ack, seen;
    logic [7:0] b;
    portIn = 4'b1010;
    busStart();
    wrByte(8'h4B, ack);
    chk(ack, "R1 read address acked", {63'd0, ack}, 64'd1);
    rdByte(1'b0, b);
    chk(b == 8'h8A, "R8 R9 status with flag set", {56'd0, b}, 64'h8A);
    clockBit(1'b1, seen);
    chk(seen == 1'b1, "R11 released after NACK", {63'd0, seen}, 64'd1);
    busStop();
    portIn = 4'b0110;
    busStart();
    wrByte(8'h4B, ack);
    rdByte(1'b1, b);
    chk(b == 8'h06, "R9 flag cleared after read", {56'd0, b}, 64'h06);
    rdByte(1'b0, b);
    chk(b == 8'h06, "R8 status repeats after ACK", {56'd0, b}, 64'h06);
    busStop();
  endtask

  task automatic t_reset_again();
    logic ack;
    logic [7:0] b;
    @(negedge clk); rstN = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    busStart();
    wrByte(8'h4B, ack);
    rdByte(1'b0, b);
    busStop();
    chk(b == 8'h86, "R9 flag set again by reset", {56'd0, b}, 64'h86);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_mismatch();
    t_write_ctrl();
    t_burst();
    t_restart();
    t_read();
    t_reset_again();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule